// File: doc/BRIEF.md
# Bulk Processor State Loader

This block is a fetch sequencer that restores a complete processor state from a fixed 102-byte region of physical memory. The region starts at a parameterised base, 0x00800 by default, and the segment registers play no part in the address. When instruction decode recognises the two-byte opcode 0F 05, it raises a one-cycle start strobe. The loader then reads the populated words of the region through a 16-bit read port with a ready handshake. It stages every word internally and transfers the whole set into a shadow register file in a single cycle.

The register file holds the following:
- the machine status word, the flags, the instruction pointer, the task selector and the local-table selector;
- four visible segment selectors and the four matching hidden descriptor caches;
- eight general registers;
- four system-table descriptors.

Each selector and each descriptor cache is taken from its own memory field, and the loader never compares them. No field is validated, so software can place the core in combinations that normal instructions cannot reach. A bus error during the fetch abandons the load and leaves the old state in place.

Top module: `ldr_state_loader`

## Requirements
- R1: While reset is held and after it is released, every register output is zero, and `mem_req_o`, `done_o` and `err_o` are low.
- R2: One cycle after a start strobe in the idle state, `mem_req_o` is high and `mem_addr_o` is base+0x006.
- R3: A load fetches exactly 41 words in this order: base+0x006, then base+0x016 to base+0x064 rising in steps of 2. Bytes base+0x000..0x005 and base+0x008..0x015 are never addressed.
- R4: `mem_req_o` and `mem_addr_o` hold steady until `mem_rdy_i` is seen high. Each rising edge with `mem_req_o` and `mem_rdy_i` both high consumes one little-endian word, in which the lower address is the low byte.
- R5: Scalar field offsets are: MSW at 0x006, task selector at 0x016, flags at 0x018, IP at 0x01A, local-table selector at 0x01C.
- R6: Selectors come from 0x01E (DS), 0x020 (SS), 0x022 (CS) and 0x024 (ES). `sel_o` packs them with ES at [15:0], CS at [31:16], SS at [47:32] and DS at [63:48]. General registers come from 0x026 (DI), 0x028 (SI), 0x02A (BP), 0x02C (SP), 0x02E (BX), 0x030 (DX), 0x032 (CX) and 0x034 (AX). `gpr_o` packs them with AX, CX, DX, BX, SP, BP, SI, DI in slices 0 to 7, 16 bits each.
- R7: A 6-byte descriptor at offset o unpacks to a 48-bit slice {limit = bytes o+5:o+4, access = byte o+3, base = bytes o+2:o}. The caches at 0x036, 0x03C, 0x042 and 0x048 feed `seg_desc_o` slices 0 (ES), 1 (CS), 2 (SS) and 3 (DS). The tables at 0x04E, 0x054, 0x05A and 0x060 feed `sys_desc_o` slices 0 (GDT), 1 (LDT), 2 (IDT) and 3 (TSS).
- R8: No register output changes until the commit. All of them change on the clock edge after the one that accepts the last word. `done_o` is high for exactly that one following cycle.
- R9: If `mem_err_i` is high with an accepted word, the load stops and `err_o` pulses for one cycle after that edge. No further request follows, no `done_o` is raised, and every register output keeps its previous value.
- R10: A start strobe that arrives while a load is in progress is ignored. The fetch order is unaffected and only one `done_o` results.
- R11: Every field is copied bit for bit with no validity or consistency check. A selector may disagree with its cache, and the MSW may hold any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe from decode for opcode 0F 05 |
| mem_req_o | output | 1 | Read request, held until ready |
| mem_addr_o | output | 20 | Physical byte address of the requested word |
| mem_rdata_i | input | 16 | Read data, little-endian word |
| mem_rdy_i | input | 1 | Read data valid, completes the request |
| mem_err_i | input | 1 | Bus error, qualified by mem_rdy_i |
| msw_o | output | 16 | Machine status word |
| tr_o | output | 16 | Task selector |
| flags_o | output | 16 | Flags |
| ip_o | output | 16 | Instruction pointer |
| ldtr_o | output | 16 | Local-table selector |
| sel_o | output | 64 | Segment selectors ES, CS, SS, DS from low slice to high |
| gpr_o | output | 128 | General registers AX..DI from low slice to high |
| seg_desc_o | output | 192 | Descriptor caches ES, CS, SS, DS, 48 bits each |
| sys_desc_o | output | 192 | System-table descriptors GDT, LDT, IDT, TSS, 48 bits each |
| done_o | output | 1 | One-cycle pulse when the new state is committed |
| err_o | output | 1 | One-cycle pulse when a load aborts on a bus error |

## Verification
Some properties are checked by assertions on every cycle:
- the request stays stable until ready arrives;
- no address falls in the skipped gaps or outside the block;
- the register outputs stay unchanged except on a commit;
- a commit follows only the acceptance of the final word;
- done and error never coincide.

Other properties only the bench scenarios can show. These are the field steering and the descriptor unpacking against a byte image, the full address order under different memory latencies, the exact commit and abort cycles, and the preservation of the old state after an error. The bench also shows that a start strobe during a busy load leaves no trace.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int unsigned ADDR_W   = 20;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned N_WORDS  = 41;   // one word at +0x06, then 40 words from +0x16
  localparam int unsigned IDX_W    = $clog2(N_WORDS);
  localparam int unsigned OFS_MSW  = 'h06;
  localparam int unsigned OFS_RUN  = 'h16;
  localparam int unsigned OFS_LAST = OFS_RUN + 2 * (N_WORDS - 2);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_COMMIT} seq_state_e;

  typedef struct packed {
    logic [15:0] limit;
    logic [7:0]  access;
    logic [23:0] base;
  } desc_t;

  // byte address of staging word idx
  function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] run;
    run = ADDR_W'(idx - IDX_W'(1)) << 1;
    if (idx == '0) return base + ADDR_W'(OFS_MSW);
    return base + ADDR_W'(OFS_RUN) + run;
  endfunction

  // three little-endian words -> base/access/limit
  function automatic desc_t unpack_desc(logic [15:0] w0, logic [15:0] w1, logic [15:0] w2);
    desc_t d;
    d.base   = {w1[7:0], w0};
    d.access = w1[15:8];
    d.limit  = w2;
    return d;
  endfunction
endpackage

// File: rtl/ldr_seq.sv
module ldr_seq
  import ldr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h00800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mem_rdy_i,
  input  logic              mem_err_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              commit_o,
  output logic              err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             err_q;
  logic             accept_w;
  logic             last_w;

  assign accept_w = (st_q == S_FETCH) && mem_rdy_i;
  assign last_w   = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q  <= S_FETCH;
          idx_q <= '0;
        end
        S_FETCH: if (accept_w) begin
          if (mem_err_i) begin
            st_q  <= S_IDLE;
            err_q <= 1'b1;
          end else if (last_w) begin
            st_q <= S_COMMIT;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        S_COMMIT: st_q <= S_IDLE;
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == S_FETCH);
  assign mem_addr_o = word_addr(BASE_ADDR, idx_q);
  assign wr_en_o    = accept_w && !mem_err_i;
  assign wr_idx_o   = idx_q;
  assign commit_o   = (st_q == S_COMMIT);
  assign err_o      = err_q;

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r3_skip_gaps: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (!mem_addr_o[0] && mem_addr_o >= BASE_ADDR + ADDR_W'(OFS_MSW)
                   && !(mem_addr_o > BASE_ADDR + ADDR_W'(OFS_MSW) && mem_addr_o < BASE_ADDR + ADDR_W'(OFS_RUN))
                   && mem_addr_o <= BASE_ADDR + ADDR_W'(OFS_LAST)));

  a_r8_commit_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(mem_req_o && mem_rdy_i && !mem_err_i && mem_addr_o == BASE_ADDR + ADDR_W'(OFS_LAST)));

  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!mem_req_o && !commit_o));
endmodule

// File: rtl/ldr_stage.sv
module ldr_stage
  import ldr_pkg::*;
#(
  parameter int unsigned DEPTH = N_WORDS,
  parameter int unsigned DW    = WORD_W
) (
  input  logic                        clk,
  input  logic                        wr_en_i,
  input  logic [$clog2(DEPTH)-1:0]    wr_idx_i,
  input  logic [DW-1:0]               wr_data_i,
  output logic [DEPTH-1:0][DW-1:0]    words_o
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en_i && wr_idx_i == ($clog2(DEPTH))'(k)) words_o[k] <= wr_data_i;
    end
  end
endmodule

// File: rtl/ldr_state_loader.sv
module ldr_state_loader
  import ldr_pkg::*;
#(
  parameter logic [19:0] BASE_ADDR = 20'h00800
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  output logic         mem_req_o,
  output logic [19:0]  mem_addr_o,
  input  logic [15:0]  mem_rdata_i,
  input  logic         mem_rdy_i,
  input  logic         mem_err_i,
  output logic [15:0]  msw_o,
  output logic [15:0]  tr_o,
  output logic [15:0]  flags_o,
  output logic [15:0]  ip_o,
  output logic [15:0]  ldtr_o,
  output logic [63:0]  sel_o,
  output logic [127:0] gpr_o,
  output logic [191:0] seg_desc_o,
  output logic [191:0] sys_desc_o,
  output logic         done_o,
  output logic         err_o
);
  localparam int unsigned N_SEG   = 4;
  localparam int unsigned N_GPR   = 8;
  localparam int unsigned N_SYS   = 4;
  localparam int unsigned DESC_W  = $bits(desc_t);
  // staging word indices of field groups
  localparam int unsigned W_SEL_TOP = 8;   // ES sits at word 8, DS at word 5
  localparam int unsigned W_GPR_TOP = 16;  // AX at word 16, DI at word 9
  localparam int unsigned W_CACHE   = 17;
  localparam int unsigned W_SYS     = 29;

  logic                            wr_en_w;
  logic [IDX_W-1:0]                wr_idx_w;
  logic                            commit_w;
  logic [N_WORDS-1:0][WORD_W-1:0]  words_w;
  logic                            done_q;

  ldr_seq #(.BASE_ADDR(BASE_ADDR)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_rdy_i  (mem_rdy_i),
    .mem_err_i  (mem_err_i),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .wr_en_o    (wr_en_w),
    .wr_idx_o   (wr_idx_w),
    .commit_o   (commit_w),
    .err_o      (err_o)
  );

  ldr_stage #(.DEPTH(N_WORDS), .DW(WORD_W)) i_stage (
    .clk       (clk),
    .wr_en_i   (wr_en_w),
    .wr_idx_i  (wr_idx_w),
    .wr_data_i (mem_rdata_i),
    .words_o   (words_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msw_o   <= '0;
      tr_o    <= '0;
      flags_o <= '0;
      ip_o    <= '0;
      ldtr_o  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit_w;
      if (commit_w) begin
        msw_o   <= words_w[0];
        tr_o    <= words_w[1];
        flags_o <= words_w[2];
        ip_o    <= words_w[3];
        ldtr_o  <= words_w[4];
      end
    end
  end

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    localparam int unsigned WS = W_SEL_TOP - s;
    localparam int unsigned WC = W_CACHE + 3 * s;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_o[16*s +: 16]           <= '0;
        seg_desc_o[DESC_W*s +: DESC_W] <= '0;
      end else if (commit_w) begin
        sel_o[16*s +: 16]           <= words_w[WS];
        seg_desc_o[DESC_W*s +: DESC_W] <= unpack_desc(words_w[WC], words_w[WC+1], words_w[WC+2]);
      end
    end
  end

  for (genvar g = 0; g < N_GPR; g++) begin : g_gpr
    localparam int unsigned WG = W_GPR_TOP - g;
    always_ff @(posedge clk) begin
      if (!rst_n)        gpr_o[16*g +: 16] <= '0;
      else if (commit_w) gpr_o[16*g +: 16] <= words_w[WG];
    end
  end

  for (genvar t = 0; t < N_SYS; t++) begin : g_sys
    localparam int unsigned WT = W_SYS + 3 * t;
    always_ff @(posedge clk) begin
      if (!rst_n)        sys_desc_o[DESC_W*t +: DESC_W] <= '0;
      else if (commit_w) sys_desc_o[DESC_W*t +: DESC_W] <= unpack_desc(words_w[WT], words_w[WT+1], words_w[WT+2]);
    end
  end

  assign done_o = done_q;

  // R8 / R9: state is only ever written by a commit
  a_r8_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> ($stable(msw_o) && $stable(tr_o) && $stable(flags_o) && $stable(ip_o)
                   && $stable(ldtr_o) && $stable(sel_o) && $stable(gpr_o)
                   && $stable(seg_desc_o) && $stable(sys_desc_o)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
endmodule

// File: tb/test_ldr_state_loader.sv
module test_ldr_state_loader;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mem_req;
  logic [19:0]  mem_addr;
  logic [15:0]  mem_rdata = '0;
  logic         mem_rdy = 1'b0;
  logic         mem_err = 1'b0;
  logic [15:0]  msw, tr, flags, ip, ldtr;
  logic [63:0]  sel;
  logic [127:0] gpr;
  logic [191:0] segd, sysd;
  logic         done, err;

  always #5ns clk = ~clk;

  ldr_state_loader i_ldr_state_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_rdy_i(mem_rdy), .mem_err_i(mem_err),
    .msw_o(msw), .tr_o(tr), .flags_o(flags), .ip_o(ip), .ldtr_o(ldtr),
    .sel_o(sel), .gpr_o(gpr), .seg_desc_o(segd), .sys_desc_o(sysd),
    .done_o(done), .err_o(err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc = 0;
  logic [7:0]  img [0:101];
  logic [19:0] q_addr [$];
  int lat = 0, err_at = -1, served = 0, wait_cnt = 0, acc_cyc = 0;
  logic [19:0] held_addr = '0;

  wire [655:0] all_out = {msw, tr, flags, ip, ldtr, sel, gpr, segd, sysd};

  task automatic chk(string tag, logic [191:0] got, logic [191:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] e16(int o);
    return {img[o+1], img[o]};
  endfunction
  function automatic logic [47:0] e48(int o);
    return {img[o+5], img[o+4], img[o+3], img[o+2], img[o+1], img[o]};
  endfunction

  always @(posedge clk) cyc++;

  // memory model and address monitor
  always @(negedge clk) begin
    mem_rdy = 1'b0;
    mem_err = 1'b0;
    if (rst_n && mem_req) begin
      if (wait_cnt > 0) chk("R4 addr held while waiting", 192'(mem_addr), 192'(held_addr));
      if (wait_cnt < lat) begin
        held_addr = mem_addr;
        wait_cnt++;
      end else begin
        int off;
        wait_cnt = 0;
        off = int'(mem_addr) - 'h800;
        if (q_addr.size() == 0) chk("R3 extra fetch", 192'(mem_addr), 192'(0));
        else chk("R3 fetch order", 192'(mem_addr), 192'(q_addr.pop_front()));
        mem_rdata = (off >= 0 && off < 101) ? {img[off+1], img[off]} : 16'h0;
        mem_rdy = 1'b1;
        mem_err = (served == err_at);
        served++;
        acc_cyc = cyc + 1;
      end
    end
  end

  task automatic fill(int seed);
    for (int i = 0; i < 102; i++) img[i] = 8'((i * 37) + (seed * 11) + ((i >> 3) * seed));
  endtask

  task automatic check_fields();
    chk("R5 msw", 192'(msw), 192'(e16('h06)));
    chk("R5 task sel", 192'(tr), 192'(e16('h16)));
    chk("R5 flags", 192'(flags), 192'(e16('h18)));
    chk("R5 ip", 192'(ip), 192'(e16('h1A)));
    chk("R5 local sel", 192'(ldtr), 192'(e16('h1C)));
    chk("R6 selectors", 192'(sel), 192'({e16('h1E), e16('h20), e16('h22), e16('h24)}));
    chk("R6 gprs", 192'(gpr), 192'({e16('h26), e16('h28), e16('h2A), e16('h2C),
                                    e16('h2E), e16('h30), e16('h32), e16('h34)}));
    chk("R7 seg caches", segd, {e48('h48), e48('h42), e48('h3C), e48('h36)});
    chk("R7 sys tables", sysd, {e48('h60), e48('h5A), e48('h54), e48('h4E)});
  endtask

  task automatic run_load(int l, int e, bit poke);
    logic [655:0] snap;
    bit fin, moved;
    int n;
    snap = all_out;
    lat = l; err_at = e; served = 0; wait_cnt = 0;
    q_addr.delete();
    n = (e >= 0) ? e + 1 : 41;
    for (int k = 0; k < n; k++) q_addr.push_back(k == 0 ? 20'h00806 : 20'(20'h00816 + 2 * (k - 1)));
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 req after start", 192'(mem_req), 192'(1));
    chk("R2 first address", 192'(mem_addr), 192'(20'h00806));
    fin = 1'b0; moved = 1'b0;
    for (int t = 0; t < 3000 && !fin; t++) begin
      @(negedge clk);
      start = poke && (t == 20);   // R10: strobe while busy
      if (done || err) fin = 1'b1;
      else if (all_out !== snap) moved = 1'b1;
    end
    start = 1'b0;
    chk("R8 watchdog finished", 192'(fin), 192'(1));
    chk("R8 no change before commit", 192'(moved), 192'(0));
    chk("R3 all words fetched", 192'(q_addr.size()), 192'(0));
    if (e < 0) begin
      chk("R8 done high", 192'(done), 192'(1));
      chk("R8 commit one cycle after last word", 192'(cyc), 192'(acc_cyc + 1));
      check_fields();
      @(negedge clk);
      chk("R8 done is a pulse", 192'(done), 192'(0));
    end else begin
      chk("R9 err pulse", 192'(err), 192'(1));
      chk("R9 err timing", 192'(cyc), 192'(acc_cyc));
      chk("R9 state preserved", 192'(all_out === snap), 192'(1));
      @(negedge clk);
      chk("R9 err is a pulse", 192'(err), 192'(0));
    end
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      if (done || mem_req) begin
        chk("R10 R9 no restart or second done", 192'({done, mem_req}), 192'(0));
        break;
      end
    end
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog expired got running exp finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs zero in reset", 192'(all_out == '0), 192'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs zero after reset", 192'(all_out == '0), 192'(1));
    chk("R1 control low", 192'({mem_req, done, err}), 192'(0));

    fill(1);
    run_load(0, -1, 1'b0);          // back-to-back handshakes
    fill(2);
    run_load(2, -1, 1'b1);          // R10: slow memory, extra start
    fill(5);
    run_load(1, 20, 1'b0);          // R9: bus error at word 20
    fill(5);
    run_load(0, 0, 1'b0);           // R9: bus error on the first word
    // R11: inconsistent selector/cache and odd MSW pass unchecked
    fill(3);
    img['h06] = 8'hFE; img['h07] = 8'hFF;
    img['h22] = 8'h00; img['h23] = 8'h00;
    img['h3C] = 8'hFF; img['h3F] = 8'h00; img['h40] = 8'h00; img['h41] = 8'h00;
    run_load(1, -1, 1'b0);
    chk("R11 msw verbatim", 192'(msw), 192'(16'hFFFE));
    chk("R11 cs selector vs cache", 192'({sel[31:16], segd[95:48]}), 192'({16'h0000, e48('h3C)}));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule